// File: doc/BRIEF.md
# Timer Clock-Select Strobe Generator

This block turns a 3-bit clock-select code into a single-cycle count-enable strobe for a timer core. The strobe comes from one of three places. It can fire on every system clock. It can fire at one of four divided rates tapped from a shared, free-running prescaler. It can fire on a chosen edge of an asynchronous event pin. A fourth setting holds the strobe low, which stops the timer.

The event pin passes through a two-stage synchroniser and then an edge detector, all inside the block. Each qualifying transition therefore yields exactly one strobe. The prescaler never stops and never restarts when the selection changes. Switching between divide ratios keeps the phase of the prescaler, and a ratio always lines up with the same free-running count.

Top module: `tick_src`

## Requirements
- R1: Select code 000 holds `tickOut` low on every cycle, whatever the event pin does.
- R2: Select code 001 drives `tickOut` high on every cycle, starting one clock edge after the code is applied.
- R3: Select codes 010, 011, 100 and 101 divide by 8, 64, 256 and 1024. Let E be the number of rising clock edges since reset was released. `tickOut` is high exactly when E is a nonzero multiple of the divide ratio.
- R4: The prescaler keeps counting through any change of select code. After a switch to another divide ratio, strobes follow the rule of R3 with no restart of phase.
- R5: Select code 110 counts falling transitions of `extPin`. Each one gives one strobe, one cycle wide, visible after the third rising clock edge that follows the transition.
- R6: Select code 111 counts rising transitions of `extPin` with the same one-strobe, three-edge timing. A pin that toggles on every clock gives one strobe per rising transition.
- R7: In the edge-counting codes, a transition of the unselected polarity gives no strobe, and no strobe is ever longer than one cycle.
- R8: While `rstN` is low, `tickOut` is low and the prescaler is held at zero. After release, the first divide-by-8 strobe comes at E = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selIn | input | 3 | Clock-select code (see R1 to R6) |
| extPin | input | 1 | Asynchronous external event input |
| tickOut | output | 1 | Registered count-enable strobe |

## Verification
Every divide code is swept for more than two full periods. The expected strobe is computed from a count of edges kept in the bench, so a wrong tap or an off-by-one phase is caught. The divide codes are then switched back and forth without a reset, which tells a free-running prescaler apart from one that restarts on a change. A reset in mid-run checks that the prescaler is cleared. The event pin is driven with single rising and falling steps in both edge codes, and also toggled on every clock. These patterns separate the correct polarity from the wrong one, check the three-edge latency, and check that fast toggling is counted without loss or duplication. The pin also toggles while the block is stopped, to check that it is ignored.

// File: rtl/tick_src_pkg.sv
package tick_src_pkg;

  typedef enum logic [2:0] {
    SEL_STOP     = 3'd0,
    SEL_DIV1     = 3'd1,
    SEL_DIV8     = 3'd2,
    SEL_DIV64    = 3'd3,
    SEL_DIV256   = 3'd4,
    SEL_DIV1024  = 3'd5,
    SEL_EXT_FALL = 3'd6,
    SEL_EXT_RISE = 3'd7
  } clkSel_e;

  localparam int NUM_TAPS = 4;
  localparam int TAP_IDX_W = $clog2(NUM_TAPS);

  // Strobe-enable bundle from control to datapath.
  typedef struct packed {
    logic                 runAll;
    logic                 useTap;
    logic [TAP_IDX_W-1:0] tapIdx;
    logic                 extRise;
    logic                 extFall;
  } tickCtl_t;

  // log2 of the divide ratio of each prescaler tap
  function automatic int tapBits(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tick_src_ctrl.sv
module tick_src_ctrl
  import tick_src_pkg::*;
(
  input  logic [2:0] selIn,
  output tickCtl_t   ctlOut
);

  always_comb begin
    ctlOut = '0;
    case (clkSel_e'(selIn))
      SEL_STOP:     ctlOut = '0;
      SEL_DIV1:     ctlOut.runAll = 1'b1;
      SEL_DIV8, SEL_DIV64, SEL_DIV256, SEL_DIV1024: begin
        ctlOut.useTap = 1'b1;
        ctlOut.tapIdx = TAP_IDX_W'(selIn - 3'd2);
      end
      SEL_EXT_FALL: ctlOut.extFall = 1'b1;
      SEL_EXT_RISE: ctlOut.extRise = 1'b1;
      default:      ctlOut = '0;
    endcase
  end

endmodule

// File: rtl/tick_src_dp.sv
module tick_src_dp
  import tick_src_pkg::*;
#(
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  tickCtl_t ctlIn,
  input  logic     extPin,
  output logic     tickOut
);

  logic [PRE_W-1:0]       preCnt;
  logic [NUM_TAPS-1:0]    tapWrap;
  logic [SYNC_STAGES-1:0] syncReg;
  logic                   lvlPrev;
  logic                   syncLvl;
  logic                   riseEv;
  logic                   fallEv;
  logic                   tickNext;

  // Free-running prescaler, never gated by the selection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + PRE_W'(1);
  end

  // One wrap detector per divide tap
  for (genvar g = 0; g < NUM_TAPS; g++) begin : gTap
    localparam int TB = tapBits(g);
    localparam logic [PRE_W-1:0] TAP_MASK = PRE_W'((1 << TB) - 1);
    assign tapWrap[g] = ((preCnt & TAP_MASK) == TAP_MASK);
  end

  // Synchroniser followed by edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg <= '0;
      lvlPrev <= 1'b0;
    end else begin
      syncReg <= {syncReg[SYNC_STAGES-2:0], extPin};
      lvlPrev <= syncReg[SYNC_STAGES-1];
    end
  end

  assign syncLvl = syncReg[SYNC_STAGES-1];
  assign riseEv  = syncLvl & ~lvlPrev;
  assign fallEv  = ~syncLvl & lvlPrev;

  assign tickNext = ctlIn.runAll
                  | (ctlIn.useTap  & tapWrap[ctlIn.tapIdx])
                  | (ctlIn.extRise & riseEv)
                  | (ctlIn.extFall & fallEv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickOut <= 1'b0;
    else       tickOut <= tickNext;
  end

endmodule

// File: rtl/tick_src.sv
module tick_src
  import tick_src_pkg::*;
#(
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] selIn,
  input  logic       extPin,
  output logic       tickOut
);

  tickCtl_t tickCtl;

  tick_src_ctrl uCtrl (
    .selIn (selIn),
    .ctlOut(tickCtl)
  );

  tick_src_dp #(
    .PRE_W      (PRE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctlIn  (tickCtl),
    .extPin (extPin),
    .tickOut(tickOut)
  );

endmodule

// File: rtl/tick_src_chk.sv
module tick_src_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] selIn,
  input logic       tickOut
);

  logic [31:0] edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= '0;
    else       edgeCnt <= edgeCnt + 32'd1;
  end

  function automatic logic [31:0] divMask(input logic [2:0] s);
    case (s)
      3'd2:    return 32'd7;
      3'd3:    return 32'd63;
      3'd4:    return 32'd255;
      default: return 32'd1023;
    endcase
  endfunction

  // R1
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selIn == 3'd0) |=> !tickOut);

  // R2
  every_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selIn == 3'd1) |=> tickOut);

  // R3
  div_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selIn >= 3'd2 && selIn <= 3'd5) |=>
      (tickOut == (edgeCnt != 32'd0 && (edgeCnt & $past(divMask(selIn))) == 32'd0)));

  // R7
  ext_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selIn[2:1] == 2'b11 && tickOut && $past(selIn[2:1]) == 2'b11) |=> !tickOut);

endmodule

bind tick_src tick_src_chk uChk (
  .clk    (clk),
  .rstN   (rstN),
  .selIn  (selIn),
  .tickOut(tickOut)
);

// File: tb/tb_tick_src.sv
module tb_tick_src;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] selIn = 3'd0;
  logic       extPin = 1'b0;
  logic       tickOut;

  int nChecks = 0;
  int nFail = 0;
  int edges = 0;
  bit done = 1'b0;

  tick_src dut (
    .clk    (clk),
    .rstN   (rstN),
    .selIn  (selIn),
    .extPin (extPin),
    .tickOut(tickOut)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) edges <= 0;
    else       edges <= edges + 1;
  end

  task automatic checkEq(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: tickOut=%0b expected %0b at edge %0d", req, act, exp, edges);
    end
  endtask

  task automatic runDiv(input logic [2:0] sel, input int n, input int cycles, input string req);
    @(negedge clk);
    selIn = sel;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      checkEq(req, tickOut, (edges != 0) && (edges % n == 0));
    end
  endtask

  task automatic extStep(input logic lvl, input logic expStrobe, input string req);
    @(negedge clk);
    extPin = lvl;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      checkEq(req, tickOut, expStrobe && (k == 3));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    checkEq("R8", tickOut, 1'b0);
    rstN = 1'b1;

    // R1 stop, with the pin toggling
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      extPin = ~extPin;
      checkEq("R1", tickOut, 1'b0);
    end
    extPin = 1'b0;
    repeat (4) @(negedge clk);

    // R2 undivided
    @(negedge clk);
    selIn = 3'd1;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk);
      @(negedge clk);
      checkEq("R2", tickOut, 1'b1);
    end

    // R3 every divide ratio over more than two periods
    runDiv(3'd2, 8, 40, "R3");
    runDiv(3'd3, 64, 200, "R3");
    runDiv(3'd4, 256, 600, "R3");
    runDiv(3'd5, 1024, 2100, "R3");

    // R4 switching ratios without reset keeps phase
    runDiv(3'd2, 8, 37, "R4");
    runDiv(3'd5, 1024, 1100, "R4");
    runDiv(3'd3, 64, 150, "R4");
    runDiv(3'd2, 8, 21, "R4");
    runDiv(3'd4, 256, 300, "R4");

    // R8 reset in mid-run clears the prescaler
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkEq("R8", tickOut, 1'b0);
    end
    selIn = 3'd2;
    rstN = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk);
      @(negedge clk);
      checkEq("R8", tickOut, (edges != 0) && (edges % 8 == 0));
    end

    // R6 rising edges, R7 the opposite polarity is ignored
    @(negedge clk);
    selIn = 3'd7;
    repeat (4) @(negedge clk);
    extStep(1'b1, 1'b1, "R6");
    extStep(1'b0, 1'b0, "R7");
    extStep(1'b1, 1'b1, "R6");
    extStep(1'b0, 1'b0, "R7");

    // R6 pin toggling every clock: one strobe per rising transition
    begin
      int strobes = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (tickOut) strobes++;
        extPin = ~extPin;
      end
      extPin = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (tickOut) strobes++;
      end
      nChecks++;
      if (strobes != 10) begin
        nFail++;
        $display("FAIL R6: strobes=%0d expected %0d", strobes, 10);
      end
    end

    // R5 falling edges, R7 rising ignored
    @(negedge clk);
    selIn = 3'd6;
    repeat (4) @(negedge clk);
    extStep(1'b1, 1'b0, "R7");
    extStep(1'b0, 1'b1, "R5");
    extStep(1'b1, 1'b0, "R7");
    extStep(1'b0, 1'b1, "R5");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule